// File: doc/BRIEF.md
# Memory issue policy scheduler

The block picks at most one memory operation per cycle from an ordered queue of `N` entries and grants it for issue. Each entry holds either a load or a store. A store is scheduled as two separate operations: an address part and a data part. Each part has its own ready flag and its own issued flag. A head pointer marks the oldest entry. The age of an entry is its distance from the head, counted modulo `N` with wrap-around.

A 2-bit configuration input selects one of four ordering policies. The policies range from strict program order to fully speculative load issue. Among all operations the selected policy allows, the oldest is granted. The block marks a granted operation as issued, so it is not offered again. The enclosing queue frees an entry by dropping its valid bit for at least one cycle, and this clears the entry's issued state. Address comparison and recovery from a wrongly ordered load are handled by the surrounding logic.

Top module: `mem_issue_sched`

## Requirements
- R1: At most one bit of `grant_o` is high in any cycle. A grant goes only to a valid entry whose granted part is ready: `addr_rdy_i` for a load or a store-address part, and `data_rdy_i` for a store-data part.
- R2: An operation part that has been granted is never granted again while its entry stays valid. Holding `valid_i` low for one cycle clears both issued flags of that entry.
- R3: Policy `2'b00` (strict order): only the entry at `head_i` may be granted.
- R4: Policy `2'b01`: a load is eligible only when every older valid store has issued both of its parts. Loads may pass each other.
- R5: Policy `2'b10`: a load is eligible once every older valid store has issued its address part, whether or not that store's data part has issued.
- R6: Policy `2'b11`: a load is eligible as soon as its own `addr_rdy_i` is high, regardless of older stores.
- R7: Under policies `2'b01`, `2'b10` and `2'b11`, a store part is eligible only when every older valid entry has fully issued. A load has fully issued once its single part has issued. A store has fully issued once both of its parts have issued.
- R8: The grant goes to the eligible entry with the smallest age `(index - head_i) mod N`, wrapping past the last index. Within one store, the address part wins over the data part when both are eligible.
- R9: `grant_data_o` is 1 exactly when the granted operation is a store-data part. It is 0 when nothing is granted.
- R10: Reset (`rst_ni` low) clears every issued flag. The first cycle after reset grants a ready head load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| policy_i | input | 2 | Ordering policy: 00 strict, 01 loads free among loads, 10 loads wait on older store addresses, 11 speculative |
| head_i | input | $clog2(N) | Index of the oldest entry |
| valid_i | input | N | Entry holds a live operation |
| is_store_i | input | N | 1 = store, 0 = load |
| addr_rdy_i | input | N | Load operands ready, or store address ready |
| data_rdy_i | input | N | Store data ready (ignored for loads) |
| grant_o | output | N | One-hot grant, or zero when nothing is granted |
| grant_data_o | output | 1 | Granted operation is a store-data part |

## Verification
The issued flags and the age order are the block's only hidden state. A stale issued flag shows up in the same cycle in one of two ways: a ready operation is never granted, or a grant appears twice for the same part. A wrong age comparison grants the wrong entry in the first cycle where two eligible entries compete, or where a blocking store sits between the head and a load. A reference model compares every cycle's grant under all four policies, with random head movement and entry recycling. Directed sequences cover wrap-around past the last index, data-pending stores, and speculative loads.

// File: rtl/mis_pkg.sv
package mis_pkg;
  typedef enum logic [1:0] {
    POL_INORDER = 2'b00,
    POL_LD_FREE = 2'b01,
    POL_LD_ADDR = 2'b10,
    POL_SPEC    = 2'b11
  } policy_e;
endpackage

// File: rtl/mis_state.sv
module mis_state #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] valid_i,
  input  logic [N-1:0] grant_i,
  input  logic         grant_data_i,
  output logic [N-1:0] iss_a_o,
  output logic [N-1:0] iss_d_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      iss_a_o <= '0;
      iss_d_o <= '0;
    end else begin
      for (int e = 0; e < N; e++) begin
        if (!valid_i[e]) begin
          iss_a_o[e] <= 1'b0;
          iss_d_o[e] <= 1'b0;
        end else if (grant_i[e]) begin
          if (grant_data_i) iss_d_o[e] <= 1'b1;
          else              iss_a_o[e] <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/mis_block.sv
module mis_block
  import mis_pkg::*;
#(
  parameter int N  = 8,
  localparam int IW = $clog2(N)
) (
  input  policy_e       policy_i,
  input  logic [IW-1:0] head_i,
  input  logic [N-1:0]  valid_i,
  input  logic [N-1:0]  is_store_i,
  input  logic [N-1:0]  iss_a_i,
  input  logic [N-1:0]  iss_d_i,
  output logic [N-1:0]  ld_ok_o,
  output logic [N-1:0]  st_ok_o
);
  logic [IW-1:0] age [N];
  logic [N-1:0]  open_any, open_st, open_sta;

  // per-entry blocking contributions
  assign open_any = valid_i & ~(iss_a_i & (~is_store_i | iss_d_i));
  assign open_st  = open_any & is_store_i;
  assign open_sta = valid_i & is_store_i & ~iss_a_i;

  for (genvar e = 0; e < N; e++) begin : g_age
    assign age[e] = IW'(e) - head_i;
  end

  for (genvar e = 0; e < N; e++) begin : g_ent
    logic blk_any, blk_st, blk_sta;
    always_comb begin
      blk_any = 1'b0;
      blk_st  = 1'b0;
      blk_sta = 1'b0;
      for (int j = 0; j < N; j++) begin
        if (age[j] < age[e]) begin
          blk_any = blk_any | open_any[j];
          blk_st  = blk_st  | open_st[j];
          blk_sta = blk_sta | open_sta[j];
        end
      end
    end

    always_comb begin
      unique case (policy_i)
        POL_INORDER: begin
          ld_ok_o[e] = (age[e] == '0);
          st_ok_o[e] = (age[e] == '0);
        end
        POL_LD_FREE: begin
          ld_ok_o[e] = !blk_st;
          st_ok_o[e] = !blk_any;
        end
        POL_LD_ADDR: begin
          ld_ok_o[e] = !blk_sta;
          st_ok_o[e] = !blk_any;
        end
        default: begin
          ld_ok_o[e] = 1'b1;
          st_ok_o[e] = !blk_any;
        end
      endcase
    end
  end
endmodule

// File: rtl/mis_pick.sv
module mis_pick #(
  parameter int N  = 8,
  localparam int IW = $clog2(N)
) (
  input  logic [IW-1:0] head_i,
  input  logic [N-1:0]  req_i,
  output logic [N-1:0]  gnt_o
);
  logic [IW-1:0] idx;
  logic          found;

  // oldest-first scan from the head, wrapping
  always_comb begin
    gnt_o = '0;
    found = 1'b0;
    idx   = '0;
    for (int k = 0; k < N; k++) begin
      idx = head_i + IW'(k);
      if (!found && req_i[idx]) begin
        gnt_o[idx] = 1'b1;
        found      = 1'b1;
      end
    end
  end
endmodule

// File: rtl/mem_issue_sched.sv
module mem_issue_sched
  import mis_pkg::*;
#(
  parameter int N  = 8,
  localparam int IW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    policy_i,
  input  logic [IW-1:0] head_i,
  input  logic [N-1:0]  valid_i,
  input  logic [N-1:0]  is_store_i,
  input  logic [N-1:0]  addr_rdy_i,
  input  logic [N-1:0]  data_rdy_i,
  output logic [N-1:0]  grant_o,
  output logic          grant_data_o
);
  logic [N-1:0] iss_a, iss_d, ld_ok, st_ok;
  logic [N-1:0] cand_ld, cand_sta, cand_std, el_a, el_d;

  mis_state #(.N(N)) u_state (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .valid_i      (valid_i),
    .grant_i      (grant_o),
    .grant_data_i (grant_data_o),
    .iss_a_o      (iss_a),
    .iss_d_o      (iss_d)
  );

  mis_block #(.N(N)) u_block (
    .policy_i   (policy_e'(policy_i)),
    .head_i     (head_i),
    .valid_i    (valid_i),
    .is_store_i (is_store_i),
    .iss_a_i    (iss_a),
    .iss_d_i    (iss_d),
    .ld_ok_o    (ld_ok),
    .st_ok_o    (st_ok)
  );

  assign cand_ld  = valid_i & ~is_store_i & addr_rdy_i & ~iss_a;
  assign cand_sta = valid_i &  is_store_i & addr_rdy_i & ~iss_a;
  assign cand_std = valid_i &  is_store_i & data_rdy_i & ~iss_d;

  // address part outranks data part within one store
  assign el_a = (cand_ld & ld_ok) | (cand_sta & st_ok);
  assign el_d = cand_std & st_ok;

  mis_pick #(.N(N)) u_pick (
    .head_i (head_i),
    .req_i  (el_a | el_d),
    .gnt_o  (grant_o)
  );

  assign grant_data_o = |(grant_o & ~el_a);
endmodule

// File: rtl/mem_issue_sched_chk.sv
module mem_issue_sched_chk #(
  parameter int N  = 8,
  localparam int IW = $clog2(N)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [1:0]    policy_i,
  input logic [IW-1:0] head_i,
  input logic [N-1:0]  valid_i,
  input logic [N-1:0]  is_store_i,
  input logic [N-1:0]  addr_rdy_i,
  input logic [N-1:0]  data_rdy_i,
  input logic [N-1:0]  grant_o,
  input logic          grant_data_o
);
  logic [N-1:0] seen_a, seen_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_a <= '0;
      seen_d <= '0;
    end else begin
      seen_a <= valid_i & (seen_a | (grant_o & {N{!grant_data_o}}));
      seen_d <= valid_i & (seen_d | (grant_o & {N{grant_data_o}}));
    end
  end

  AST_ONE_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o)); // R1

  AST_DATA_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o == '0) |-> !grant_data_o); // R9

  AST_DATA_STORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_data_o |-> ((grant_o & is_store_i & data_rdy_i) != '0)); // R9

  AST_HEAD_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (policy_i == 2'b00 && grant_o != '0) |-> grant_o[head_i]); // R3

  for (genvar e = 0; e < N; e++) begin : g_chk
    AST_GRANT_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      grant_o[e] |-> valid_i[e]); // R1

    AST_ADDR_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (grant_o[e] && !grant_data_o) |-> addr_rdy_i[e]); // R1

    AST_NO_REGRANT_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (grant_o[e] && !grant_data_o) |-> !seen_a[e]); // R2

    AST_NO_REGRANT_D: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (grant_o[e] && grant_data_o) |-> !seen_d[e]); // R2
  end
endmodule

bind mem_issue_sched mem_issue_sched_chk #(.N(N)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .policy_i     (policy_i),
  .head_i       (head_i),
  .valid_i      (valid_i),
  .is_store_i   (is_store_i),
  .addr_rdy_i   (addr_rdy_i),
  .data_rdy_i   (data_rdy_i),
  .grant_o      (grant_o),
  .grant_data_o (grant_data_o)
);

// File: tb/mem_issue_sched_test.sv
module mem_issue_sched_test;
  localparam int N  = 8;
  localparam int IW = $clog2(N);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    pol = 2'b00;
  logic [IW-1:0] head = '0;
  logic [N-1:0]  vld = '0, st = '0, ar = '0, dr = '0;
  logic [N-1:0]  gnt;
  logic          gd;

  int total = 0;
  int bad   = 0;
  bit mdl_on = 0;
  bit finished = 0;

  bit m_ia [N];
  bit m_id [N];
  int m_g;
  bit m_d;

  always #2 clk = ~clk;

  mem_issue_sched #(.N(N)) uut (
    .clk_i(clk), .rst_ni(rst_n), .policy_i(pol), .head_i(head),
    .valid_i(vld), .is_store_i(st), .addr_rdy_i(ar), .data_rdy_i(dr),
    .grant_o(gnt), .grant_data_o(gd)
  );

  // behavioural reference: walk entries oldest first
  task automatic model(output int g, output bit d);
    bit older_open = 0, older_st_open = 0, older_sta_open = 0;
    bit ok_ld, ok_st, done;
    g = -1; d = 0;
    for (int k = 0; k < N; k++) begin
      int e = (int'(head) + k) % N;
      if (!vld[e]) continue;
      case (pol)
        2'd0: begin ok_ld = (k == 0); ok_st = (k == 0); end
        2'd1: begin ok_ld = !older_st_open; ok_st = !older_open; end
        2'd2: begin ok_ld = !older_sta_open; ok_st = !older_open; end
        default: begin ok_ld = 1; ok_st = !older_open; end
      endcase
      if (g < 0) begin
        if (!st[e] && ar[e] && !m_ia[e] && ok_ld) g = e;
        else if (st[e] && ar[e] && !m_ia[e] && ok_st) g = e;
        else if (st[e] && dr[e] && !m_id[e] && ok_st) begin g = e; d = 1; end
      end
      done = m_ia[e] && (!st[e] || m_id[e]);
      if (!done) older_open = 1;
      if (st[e] && !done) older_st_open = 1;
      if (st[e] && !m_ia[e]) older_sta_open = 1;
    end
  endtask

  function automatic logic [N-1:0] onehot(int g);
    logic [N-1:0] v = '0;
    if (g >= 0) v[g] = 1'b1;
    return v;
  endfunction

  always @(negedge clk) begin
    if (mdl_on && !finished) begin
      string tag;
      model(m_g, m_d);
      case (pol)
        2'd0: tag = "R3/R8";
        2'd1: tag = "R4/R7/R8";
        2'd2: tag = "R5/R7/R8";
        default: tag = "R6/R7/R8";
      endcase
      total++;
      if (gnt !== onehot(m_g) || gd !== m_d) begin
        bad++;
        $display("FAIL %s model: grant=%h data=%0b expected grant=%h data=%0b",
                 tag, gnt, gd, onehot(m_g), m_d);
      end
    end
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < N; e++) begin m_ia[e] = 0; m_id[e] = 0; end
    end else if (mdl_on) begin
      for (int e = 0; e < N; e++) begin
        if (!vld[e]) begin m_ia[e] = 0; m_id[e] = 0; end
        else if (m_g == e) begin
          if (m_d) m_id[e] = 1; else m_ia[e] = 1;
        end
      end
    end
  end

  task automatic step(input logic [N-1:0] eg, input bit ed, input string tag);
    @(negedge clk);
    #0.5;
    total++;
    if (gnt !== eg || gd !== ed) begin
      bad++;
      $display("FAIL %s: grant=%h data=%0b expected grant=%h data=%0b",
               tag, gnt, gd, eg, ed);
    end
    @(posedge clk);
    #1;
  endtask

  task automatic clear_all();
    vld = '0; st = '0; ar = '0; dr = '0;
    step('0, 0, "R2 clear");
  endtask

  initial begin
    // R10: ready head load waiting through reset
    vld = 8'h01; ar = 8'h01;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    mdl_on = 1;
    step(8'h01, 0, "R10 reset grant");
    step(8'h00, 0, "R2 after reset grant");

    // policies 1 and 2 with a data-pending store
    clear_all();
    pol = 2'b01; vld = 8'h03; st = 8'h01; ar = 8'h03; dr = 8'h00;
    step(8'h01, 0, "R8 address part first");
    step(8'h00, 0, "R4 load behind store");
    pol = 2'b10;
    step(8'h02, 0, "R5 load past address-known store");
    step(8'h00, 0, "R2 no regrant");
    dr = 8'h01;
    step(8'h01, 1, "R9 data part");
    step(8'h00, 0, "R2 store done");

    // speculative load
    clear_all();
    pol = 2'b10; vld = 8'h03; st = 8'h01; ar = 8'h02; dr = 8'h00;
    step(8'h00, 0, "R5 unknown store address blocks");
    pol = 2'b11;
    step(8'h02, 0, "R6 speculative load");
    step(8'h00, 0, "R2 spec load once");

    // wrap-around
    clear_all();
    head = 3'd6; pol = 2'b00; vld = 8'hC1; st = 8'h00; ar = 8'h81;
    step(8'h00, 0, "R3 head only");
    pol = 2'b11;
    step(8'h80, 0, "R8 oldest past head");
    step(8'h01, 0, "R8 wrap to index 0");
    step(8'h00, 0, "R2 wrap drained");

    // store held behind unfinished load
    clear_all();
    head = '0; pol = 2'b11; vld = 8'h03; st = 8'h02; ar = 8'h02; dr = 8'h02;
    step(8'h00, 0, "R7 store waits for older load");
    ar = 8'h03;
    step(8'h01, 0, "R7 load goes");
    step(8'h02, 0, "R8 store address");
    step(8'h02, 1, "R9 store data");
    step(8'h00, 0, "R1 nothing left");

    // random phase, model-compared every cycle
    clear_all();
    for (int p = 0; p < 4; p++) begin
      pol = 2'(p);
      for (int c = 0; c < 500; c++) begin
        for (int e = 0; e < N; e++) begin
          if (vld[e] && ($urandom % 16) == 0) vld[e] = 1'b0;
          else if (!vld[e] && ($urandom % 3) == 0) begin
            vld[e] = 1'b1;
            st[e] = 1'($urandom);
          end
        end
        ar = N'($urandom);
        dr = N'($urandom);
        if (($urandom % 20) == 0) head = IW'($urandom);
        @(posedge clk);
        #1;
      end
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule